// File: doc/BRIEF.md
# Fixed-Rate Serial Port with Command and Status Registers

This block is a small serial port that hangs off a processor's 8-bit I/O bus. It sends and receives frames of one start bit, eight data bits sent least significant bit first, no parity and one stop bit. The bit rate is fixed at build time by dividing the system clock; the default is 115200 baud from a 100 MHz clock. Software sees two byte-wide addresses. The first returns status on reads and takes commands on writes. The second takes a byte to transmit on writes and returns the received byte on reads.

The transmitter has no holding register, so each byte must wait until the previous frame has finished. The receiver keeps one byte. A level interrupt request tells software that this byte is waiting, provided software has enabled it. A command bit sets the level of a request-to-send output. Writing a command with its two lowest bits both set returns the whole port to its power-up state.

Top module: `tiny_uart`

## Requirements
- R1: After the synchronous reset, a status read returns 0x02, `rts` and `irq` are low and `txd` is high.
- R2: A read of address 0x80 returns status on the following clock edge. Bit 0 is receive-data-ready, bit 1 is transmit-empty and bits 7:2 are zero.
- R3: A write to 0x80 whose bits 1:0 are both 1 resets the port as R1 does. This clears data ready, stops any frame in progress, drives `rts` low and turns the interrupt enable off. A write with only one of these two bits set does not reset anything.
- R4: A command write that is not a reset copies bit 6 of the written value to `rts`, where 1 drives `rts` high.
- R5: A command write that is not a reset copies bit 7 to the interrupt enable. `irq` is high exactly when the enable is 1 and data ready is 1, and it stays high until the byte is read or the enable is cleared.
- R6: A write to 0x81 while transmit-empty is 1 drives `txd` low from the next clock edge. The frame is the start bit, then the eight data bits LSB first, then a high stop bit, each lasting DIV clocks. Transmit-empty reads 0 for the 10·DIV clocks of the frame and then returns to 1.
- R7: A write to 0x81 while a frame is being sent is ignored. The frame in progress and the bits that follow it are unchanged.
- R8: The receiver starts on a falling edge of `rxd` and checks that the line is still low half a bit later. A line that has gone high again is a glitch and is dropped. Each data bit is sampled at its centre, LSB first. A frame whose stop bit is low is discarded and leaves data ready unchanged. A good frame loads the byte and sets data ready.
- R9: A read of 0x81 returns the held byte and clears data ready.
- R10: A byte that completes while data ready is already 1 replaces the held byte, and data ready stays 1.
- R11: One bit lasts DIV = CLK_HZ / BAUD system clocks, for both transmit and receive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| io_addr | input | 8 | I/O address |
| io_wdata | input | 8 | I/O write data |
| io_wr | input | 1 | Write strobe, one clock per access |
| io_rd | input | 1 | Read strobe, one clock per access |
| io_rdata | output | 8 | Registered read data, valid after the read edge |
| rxd | input | 1 | Serial receive line, idle high |
| txd | output | 1 | Serial transmit line, idle high |
| rts | output | 1 | Request-to-send level set by software |
| irq | output | 1 | Receive-data-ready interrupt request, level |

## Verification
The bench builds the port with CLK_HZ = 1,600,000 and BAUD = 100,000, so DIV is 16 and a whole frame lasts 160 clocks. At that size the bench can check every transmitted bit at its centre, run many receive and transmit frames back to back, and drive receive glitches shorter than half a bit. It can also force overruns and overlapping transmit writes within a short run. An even DIV keeps the half-bit start check and the bit-centre sampling well inside each bit, so timing faults in the dividers show up as wrong bits.

// File: rtl/tiny_uart_pkg.sv
package tiny_uart_pkg;
  localparam logic [7:0] ADDR_CTRL  = 8'h80;
  localparam logic [7:0] ADDR_DATA  = 8'h81;
  localparam int DATA_BITS   = 8;
  localparam int FRAME_BITS  = DATA_BITS + 2;
  localparam int ST_RDY_BIT  = 0;
  localparam int ST_TXE_BIT  = 1;
  localparam int CMD_RTS_BIT = 6;
  localparam int CMD_IE_BIT  = 7;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/tiny_uart_tx.sv
module tiny_uart_tx
  import tiny_uart_pkg::*;
#(
  parameter int DIV = 868
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [DATA_BITS-1:0] data,
  output logic                 busy,
  output logic                 txd
);
  localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int IDX_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_BITS - 1);

  logic [CNT_W-1:0]   cnt;
  logic [IDX_W-1:0]   idx;
  logic [DATA_BITS:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      txd   <= 1'b1;
      cnt   <= '0;
      idx   <= '0;
      shreg <= '1;
    end else if (!busy) begin
      if (start) begin
        busy  <= 1'b1;
        txd   <= 1'b0;
        shreg <= {1'b1, data};
        cnt   <= '0;
        idx   <= '0;
      end
    end else if (cnt == CNT_LAST) begin
      cnt <= '0;
      if (idx == IDX_LAST) begin
        busy <= 1'b0;
        txd  <= 1'b1;
      end else begin
        txd   <= shreg[0];
        shreg <= {1'b1, shreg[DATA_BITS:1]};
        idx   <= idx + 1'b1;
      end
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/tiny_uart_rx.sv
module tiny_uart_rx
  import tiny_uart_pkg::*;
#(
  parameter int DIV = 868
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rxd,
  output logic                 valid,
  output logic [DATA_BITS-1:0] byte_out
);
  localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int IDX_W = $clog2(DATA_BITS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV - 1);
  localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(DIV / 2 - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_BITS - 1);

  logic             sync1, sync2, prev;
  logic             fall;
  rx_state_e        state;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1 <= 1'b1;
      sync2 <= 1'b1;
      prev  <= 1'b1;
    end else begin
      sync1 <= rxd;
      sync2 <= sync1;
      prev  <= sync2;
    end
  end

  assign fall = prev & ~sync2;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= RX_IDLE;
      cnt      <= '0;
      idx      <= '0;
      valid    <= 1'b0;
      byte_out <= '0;
    end else begin
      valid <= 1'b0;
      unique case (state)
        RX_IDLE: begin
          cnt <= '0;
          if (fall) state <= RX_START;
        end
        RX_START: begin
          if (cnt == CNT_HALF) begin
            cnt   <= '0;
            idx   <= '0;
            state <= sync2 ? RX_IDLE : RX_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_DATA: begin
          if (cnt == CNT_LAST) begin
            cnt      <= '0;
            byte_out <= {sync2, byte_out[DATA_BITS-1:1]};
            if (idx == IDX_LAST) state <= RX_STOP;
            else                 idx   <= idx + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_STOP: begin
          if (cnt == CNT_LAST) begin
            cnt   <= '0;
            valid <= sync2;
            state <= RX_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tiny_uart_regs.sv
module tiny_uart_regs
  import tiny_uart_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [7:0]           io_addr,
  input  logic [7:0]           io_wdata,
  input  logic                 io_wr,
  input  logic                 io_rd,
  input  logic                 rx_valid,
  input  logic [DATA_BITS-1:0] rx_byte,
  input  logic                 tx_busy,
  output logic [7:0]           io_rdata,
  output logic                 soft_rst,
  output logic                 tx_start,
  output logic                 rts,
  output logic                 irq,
  output logic                 rdy,
  output logic                 ie
);
  logic                 ctrl_wr, data_rd, cmd_wr;
  logic                 rdy_n, ie_n;
  logic [DATA_BITS-1:0] rx_buf;
  logic                 loc_rst;

  assign ctrl_wr  = io_wr && (io_addr == ADDR_CTRL);
  assign soft_rst = ctrl_wr && (io_wdata[1:0] == 2'b11);
  assign cmd_wr   = ctrl_wr && !soft_rst;
  assign data_rd  = io_rd && (io_addr == ADDR_DATA);
  assign tx_start = io_wr && (io_addr == ADDR_DATA);
  assign loc_rst  = rst | soft_rst;

  always_comb begin
    rdy_n = rdy;
    if (data_rd)  rdy_n = 1'b0;
    if (rx_valid) rdy_n = 1'b1;
    ie_n = cmd_wr ? io_wdata[CMD_IE_BIT] : ie;
  end

  always_ff @(posedge clk) begin
    if (loc_rst) begin
      rdy    <= 1'b0;
      ie     <= 1'b0;
      rts    <= 1'b0;
      irq    <= 1'b0;
      rx_buf <= '0;
    end else begin
      rdy <= rdy_n;
      ie  <= ie_n;
      irq <= ie_n & rdy_n;
      if (cmd_wr)   rts    <= io_wdata[CMD_RTS_BIT];
      if (rx_valid) rx_buf <= rx_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      io_rdata <= '0;
    end else if (io_rd) begin
      unique case (io_addr)
        ADDR_CTRL: begin
          io_rdata             <= '0;
          io_rdata[ST_RDY_BIT] <= rdy;
          io_rdata[ST_TXE_BIT] <= ~tx_busy;
        end
        ADDR_DATA: io_rdata <= rx_buf;
        default:   io_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/tiny_uart.sv
module tiny_uart
  import tiny_uart_pkg::*;
#(
  parameter int CLK_HZ = 100_000_000,
  parameter int BAUD   = 115_200
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] io_addr,
  input  logic [7:0] io_wdata,
  input  logic       io_wr,
  input  logic       io_rd,
  output logic [7:0] io_rdata,
  input  logic       rxd,
  output logic       txd,
  output logic       rts,
  output logic       irq
);
  localparam int DIV = CLK_HZ / BAUD;

  logic                 soft_rst, core_rst;
  logic                 tx_start, tx_busy;
  logic                 rx_valid, rx_rdy, irq_en;
  logic [DATA_BITS-1:0] rx_byte;

  assign core_rst = rst | soft_rst;

  tiny_uart_regs u_regs (
    .clk      (clk),
    .rst      (rst),
    .io_addr  (io_addr),
    .io_wdata (io_wdata),
    .io_wr    (io_wr),
    .io_rd    (io_rd),
    .rx_valid (rx_valid),
    .rx_byte  (rx_byte),
    .tx_busy  (tx_busy),
    .io_rdata (io_rdata),
    .soft_rst (soft_rst),
    .tx_start (tx_start),
    .rts      (rts),
    .irq      (irq),
    .rdy      (rx_rdy),
    .ie       (irq_en)
  );

  tiny_uart_tx #(.DIV(DIV)) u_tx (
    .clk   (clk),
    .rst   (core_rst),
    .start (tx_start),
    .data  (io_wdata),
    .busy  (tx_busy),
    .txd   (txd)
  );

  tiny_uart_rx #(.DIV(DIV)) u_rx (
    .clk      (clk),
    .rst      (core_rst),
    .rxd      (rxd),
    .valid    (rx_valid),
    .byte_out (rx_byte)
  );
endmodule

// File: rtl/tiny_uart_chk.sv
module tiny_uart_chk
  import tiny_uart_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic [7:0] io_addr,
  input logic [7:0] io_wdata,
  input logic       io_wr,
  input logic       io_rd,
  input logic [7:0] io_rdata,
  input logic       txd,
  input logic       rts,
  input logic       irq,
  input logic       tx_busy,
  input logic       rdy,
  input logic       ie,
  input logic       rx_valid
);
  logic ctl_w, sreset, dat_w, dat_r, st_r;
  assign ctl_w  = io_wr && (io_addr == ADDR_CTRL);
  assign sreset = ctl_w && io_wdata[0] && io_wdata[1];
  assign dat_w  = io_wr && (io_addr == ADDR_DATA);
  assign dat_r  = io_rd && (io_addr == ADDR_DATA);
  assign st_r   = io_rd && (io_addr == ADDR_CTRL);

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rts && !irq && txd)); // R1
  AST_STATUS_PAD: assert property (@(posedge clk) disable iff (rst)
    st_r |=> (io_rdata[7:2] == 6'd0)); // R2
  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (rst)
    sreset |=> (!rts && !irq && !rdy && !ie && !tx_busy && txd)); // R3
  AST_RTS_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    (ctl_w && !sreset) |=> (rts == $past(io_wdata[6]))); // R4
  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
    irq == (ie && rdy)); // R5
  AST_TX_LAUNCH: assert property (@(posedge clk) disable iff (rst)
    (dat_w && !tx_busy) |=> (tx_busy && !txd)); // R6
  AST_IDLE_LINE: assert property (@(posedge clk) disable iff (rst)
    !tx_busy |-> txd); // R6
  AST_RX_SETS: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !sreset) |=> rdy); // R8
  AST_RD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (dat_r && !rx_valid) |=> !rdy); // R9
  AST_OVERRUN_KEEP: assert property (@(posedge clk) disable iff (rst)
    (rdy && rx_valid && !sreset) |=> rdy); // R10
endmodule

bind tiny_uart tiny_uart_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .io_addr  (io_addr),
  .io_wdata (io_wdata),
  .io_wr    (io_wr),
  .io_rd    (io_rd),
  .io_rdata (io_rdata),
  .txd      (txd),
  .rts      (rts),
  .irq      (irq),
  .tx_busy  (tx_busy),
  .rdy      (rx_rdy),
  .ie       (irq_en),
  .rx_valid (rx_valid)
);

// File: tb/tiny_uart_tb.sv
module tiny_uart_tb;
  localparam int CLK_HZ = 1_600_000;
  localparam int BAUD   = 100_000;
  localparam int DIV    = CLK_HZ / BAUD;
  localparam logic [7:0] A_CTL = 8'h80;
  localparam logic [7:0] A_DAT = 8'h81;
  localparam int NV = 6;
  // {received byte, transmitted byte}
  localparam logic [15:0] VEC [NV] = '{16'h55A3, 16'h0001, 16'hFF80,
                                       16'h8C7E, 16'h3300, 16'hA5FF};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] io_addr = '0;
  logic [7:0] io_wdata = '0;
  logic       io_wr = 1'b0;
  logic       io_rd = 1'b0;
  logic [7:0] io_rdata;
  logic       rxd = 1'b1;
  logic       txd, rts, irq;

  int nchk = 0;
  int nfail = 0;
  logic [7:0] rv;

  always #5 clk = ~clk;

  tiny_uart #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) u_dut (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata),
    .rxd(rxd), .txd(txd), .rts(rts), .irq(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic io_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    d = io_rdata;
  endtask

  task automatic rx_send(input logic [7:0] b, input logic stop_bit);
    logic [9:0] fr;
    fr = {stop_bit, b, 1'b0};
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      rxd = fr[k];
      repeat (DIV - 1) @(negedge clk);
    end
    @(negedge clk);
    rxd = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // waits for start bit, samples each bit at its centre (R6, R11)
  task automatic tx_capture(input string tag, input logic [7:0] exp);
    logic [9:0] fr;
    logic [9:0] got;
    fr = {1'b1, exp, 1'b0};
    while (txd !== 1'b0) @(negedge clk);
    repeat (DIV / 2) @(negedge clk);
    for (int k = 0; k < 10; k++) begin
      got[k] = txd;
      if (k < 9) repeat (DIV) @(negedge clk);
    end
    chk({tag, " frame lo"}, got[7:0], fr[7:0]);
    chk({tag, " frame hi"}, {6'd0, got[9:8]}, {6'd0, fr[9:8]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R1 reset state
    io_read(A_CTL, rv);
    chk("R1 status", rv, 8'h02);
    chk("R1 rts/irq/txd", {5'd0, rts, irq, txd}, 8'h01);

    // vector walk: receive then transmit (R2 R6 R8 R9 R11)
    for (int i = 0; i < NV; i++) begin
      rx_send(VEC[i][15:8], 1'b1);
      io_read(A_CTL, rv);
      chk("R2 R8 status ready", rv, 8'h03);
      io_read(A_DAT, rv);
      chk("R9 rx byte", rv, VEC[i][15:8]);
      io_read(A_CTL, rv);
      chk("R9 ready cleared", rv, 8'h02);
      io_write(A_DAT, VEC[i][7:0]);
      io_read(A_CTL, rv);
      chk("R6 tx busy", rv, 8'h00);
      tx_capture("R6 R11", VEC[i][7:0]);
      repeat (DIV / 2 + 2) @(negedge clk);
      io_read(A_CTL, rv);
      chk("R6 tx empty again", rv, 8'h02);
    end

    // R8 bad stop bit is discarded
    rx_send(8'h5A, 1'b0);
    repeat (DIV) @(negedge clk);
    io_read(A_CTL, rv);
    chk("R8 framing discard", rv, 8'h02);

    // R8 glitch shorter than half a bit
    @(negedge clk); rxd = 1'b0;
    repeat (3) @(negedge clk); rxd = 1'b1;
    repeat (3 * DIV) @(negedge clk);
    io_read(A_CTL, rv);
    chk("R8 glitch dropped", rv, 8'h02);

    // R10 overrun keeps newest, ready stays
    rx_send(8'h11, 1'b1);
    rx_send(8'h22, 1'b1);
    io_read(A_CTL, rv);
    chk("R10 ready held", rv, 8'h03);
    io_read(A_DAT, rv);
    chk("R10 newest byte", rv, 8'h22);

    // R5 interrupt level
    io_write(A_CTL, 8'h80);
    chk("R5 irq idle", {7'd0, irq}, 8'h00);
    rx_send(8'h6B, 1'b1);
    chk("R5 irq set", {7'd0, irq}, 8'h01);
    repeat (20) @(negedge clk);
    chk("R5 irq held", {7'd0, irq}, 8'h01);
    io_read(A_DAT, rv);
    chk("R5 irq after read", {7'd0, irq}, 8'h00);
    io_write(A_CTL, 8'h00);
    rx_send(8'h6C, 1'b1);
    chk("R5 irq masked", {7'd0, irq}, 8'h00);
    io_write(A_CTL, 8'h80);
    chk("R5 irq on enable", {7'd0, irq}, 8'h01);
    io_write(A_CTL, 8'h00);
    chk("R5 irq off on disable", {7'd0, irq}, 8'h00);
    io_read(A_DAT, rv);

    // R4 rts control
    io_write(A_CTL, 8'h40);
    chk("R4 rts high", {7'd0, rts}, 8'h01);
    io_write(A_CTL, 8'h00);
    chk("R4 rts low", {7'd0, rts}, 8'h00);

    // R7 write during a frame is ignored
    io_write(A_DAT, 8'hA5);
    io_write(A_DAT, 8'h3C);
    tx_capture("R7", 8'hA5);
    repeat (DIV / 2 + 2) @(negedge clk);
    io_read(A_CTL, rv);
    chk("R7 no second frame", rv, 8'h02);
    repeat (2 * DIV) @(negedge clk);
    chk("R7 line idle", {7'd0, txd}, 8'h01);

    // R3 single bit does not reset, both bits do
    rx_send(8'h77, 1'b1);
    io_write(A_CTL, 8'hC1);
    io_read(A_CTL, rv);
    chk("R3 bit0 only no reset", rv, 8'h03);
    io_write(A_CTL, 8'hC2);
    chk("R3 bit1 only rts/irq", {6'd0, rts, irq}, 8'h03);
    io_write(A_DAT, 8'h0F);
    repeat (DIV * 3) @(negedge clk);
    io_write(A_CTL, 8'h03);
    chk("R3 soft reset pins", {5'd0, rts, irq, txd}, 8'h01);
    io_read(A_CTL, rv);
    chk("R3 soft reset status", rv, 8'h02);
    io_write(A_CTL, 8'h80);
    chk("R3 irq stays low", {7'd0, irq}, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule